// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block is the bit-level engine of an I2C master. Software, through a small register port, tells it to put a START, a repeated START or a STOP on the bus, or to clock one byte out to a slave and capture the slave's acknowledge. SCL and SDA are open-drain: the block only pulls a line low or lets it go, and an external pull-up supplies the high level.

A single command code covers both kinds of START. The acknowledge bit of the control word picks between them when software writes it. When software reads it back, the same bit shows whether the last byte was refused. Each operation sets a busy flag while it runs. When it finishes it raises a sticky session-done flag, which can be routed to an interrupt line. The length of the SCL low phase and of the SCL high phase are each a programmable number of system-clock cycles.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset every register reads zero except the two phase-length registers (addr 4 and addr 5), which read their parameter defaults. Both open-drain enables are inactive, so the lines are released, and the interrupt output is low.
- R2: The control word is at addr 0 and has these fields: bit 0 enable, bits 2:1 command (0 none, 1 start/restart, 2 stop, 3 none), bit 3 acknowledge. Writing enable=1, command=1 and acknowledge=0 while idle drives SDA low while SCL is high (a START). SCL is then held low.
- R3: Command 1 with acknowledge=1 first releases SDA while SCL is low. It then releases SCL and pulls SDA low while SCL is high, giving a repeated START with no STOP before it.
- R4: Command 2 makes SDA rise while SCL is high (a STOP). Afterwards both lines stay released.
- R5: Writing a byte to addr 1 while idle and enabled clocks out its 8 bits, MSB first. A ninth SCL pulse follows with SDA released, for the acknowledge.
- R6: After a byte, bit 3 of the control word reads 1 if SDA was high at the end of the ninth SCL high phase (NAK) and 0 if it was low (ACK).
- R7: Status bit 0 (addr 2) reads 1 from the clock edge that accepts a command or byte until that operation ends. Writes to addr 0 or addr 1 during that time are ignored.
- R8: Status bit 1 is set when a command or byte completes. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R9: The interrupt output follows status bit 1 ANDed with bit 0 of the interrupt-enable register (addr 3), one clock later.
- R10: Every SCL low phase inside a byte lasts the number of cycles in addr 4, and every SCL high phase lasts the number in addr 5. A value of 0 acts as 1.
- R11: With enable at 0, a byte write starts nothing. A command of 0 or 3 starts nothing either, and the bus does not move in either case.
- R12: During a byte, SDA never changes while SCL stays released, so no START or STOP is seen inside a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Session-done interrupt |

## Verification
A wrong sequencer state shows up on the lines within one phase. It appears as a misplaced START or STOP, a bit that does not match the written byte at the next SCL rise, or a SCL phase whose length does not match its register. A stuck bit counter shows up as a ninth clock that never comes or comes too early, so the monitored byte count changes by the wrong amount within one byte time. A broken interlock shows up as an extra byte or a changed control readback right after the busy window.

// File: rtl/i2c_cond_seq_pkg.sv
package i2c_cond_seq_pkg;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TLOW  = 3'd4;
  localparam logic [ADDR_W-1:0] A_THIGH = 3'd5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_RSVD  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_RS_LOW,
    SQ_ST_SETUP,
    SQ_ST_HOLD,
    SQ_SP_LOW,
    SQ_SP_HIGH,
    SQ_SP_REL,
    SQ_BIT_LOW,
    SQ_BIT_HIGH,
    SQ_ACK_LOW,
    SQ_ACK_HIGH
  } seq_state_e;

endpackage

// File: rtl/i2c_cond_seq_regs.sv
module i2c_cond_seq_regs
  import i2c_cond_seq_pkg::*;
#(
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned DEF_TLOW  = 5,
  parameter int unsigned DEF_THIGH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               busy,
  input  logic               done_pulse,
  input  logic               nak,
  output logic               cmd_go,
  output logic               cmd_stop,
  output logic               cmd_rs,
  output logic               byte_go,
  output logic [7:0]         byte_val,
  output logic               ien,
  output logic               done,
  output logic [PHASE_W-1:0] tlow,
  output logic [PHASE_W-1:0] thigh
);

  logic               en_q, en_d;
  logic [1:0]         op_q, op_d;
  logic               rs_q, rs_d;
  logic [7:0]         dat_q, dat_d;
  logic               ien_q, ien_d;
  logic               done_q, done_d;
  logic [PHASE_W-1:0] tlow_q, tlow_d;
  logic [PHASE_W-1:0] thigh_q, thigh_d;

  logic wr_ctrl, wr_data, wr_stat, wr_ien, wr_tlow, wr_thigh;
  logic new_op_start, new_op_stop;

  always_comb begin
    wr_ctrl  = reg_we && (reg_addr == A_CTRL) && !busy;
    wr_data  = reg_we && (reg_addr == A_DATA) && !busy;
    wr_stat  = reg_we && (reg_addr == A_STAT);
    wr_ien   = reg_we && (reg_addr == A_IEN);
    wr_tlow  = reg_we && (reg_addr == A_TLOW);
    wr_thigh = reg_we && (reg_addr == A_THIGH);

    new_op_start = (reg_wdata[2:1] == OP_START);
    new_op_stop  = (reg_wdata[2:1] == OP_STOP);

    cmd_go   = wr_ctrl && reg_wdata[0] && (new_op_start || new_op_stop);
    cmd_stop = new_op_stop;
    cmd_rs   = reg_wdata[3];
    byte_go  = wr_data && en_q;
    byte_val = reg_wdata[7:0];
  end

  always_comb begin
    en_d    = en_q;
    op_d    = op_q;
    rs_d    = rs_q;
    dat_d   = dat_q;
    ien_d   = ien_q;
    done_d  = done_q;
    tlow_d  = tlow_q;
    thigh_d = thigh_q;
    if (wr_ctrl) begin
      en_d = reg_wdata[0];
      op_d = reg_wdata[2:1];
      rs_d = reg_wdata[3];
    end
    if (wr_data)  dat_d   = reg_wdata[7:0];
    if (wr_ien)   ien_d   = reg_wdata[0];
    if (wr_tlow)  tlow_d  = reg_wdata[PHASE_W-1:0];
    if (wr_thigh) thigh_d = reg_wdata[PHASE_W-1:0];
    if (wr_stat && reg_wdata[1]) done_d = 1'b0;
    if (done_pulse) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      op_q    <= 2'b00;
      rs_q    <= 1'b0;
      dat_q   <= '0;
      ien_q   <= 1'b0;
      done_q  <= 1'b0;
      tlow_q  <= PHASE_W'(DEF_TLOW);
      thigh_q <= PHASE_W'(DEF_THIGH);
    end else begin
      en_q    <= en_d;
      op_q    <= op_d;
      rs_q    <= rs_d;
      dat_q   <= dat_d;
      ien_q   <= ien_d;
      done_q  <= done_d;
      tlow_q  <= tlow_d;
      thigh_q <= thigh_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0000, nak, op_q, en_q};
      A_DATA:  reg_rdata = dat_q;
      A_STAT:  reg_rdata = {6'b000000, done_q, busy};
      A_IEN:   reg_rdata = {7'b0000000, ien_q};
      A_TLOW:  reg_rdata = REG_W'(tlow_q);
      A_THIGH: reg_rdata = REG_W'(thigh_q);
      default: reg_rdata = '0;
    endcase
  end

  assign ien   = ien_q;
  assign done  = done_q;
  assign tlow  = tlow_q;
  assign thigh = thigh_q;

  logic unused_rs;
  assign unused_rs = rs_q;

endmodule

// File: rtl/i2c_cond_seq_timer.sv
module i2c_cond_seq_timer #(
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               use_high,
  input  logic [PHASE_W-1:0] tlow,
  input  logic [PHASE_W-1:0] thigh,
  output logic               last
);

  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic [PHASE_W-1:0] len;

  always_comb begin
    len = use_high ? thigh : tlow;
    if (len == '0) len = PHASE_W'(1);
    cnt_d = cnt_q;
    if (load)             cnt_d = len - PHASE_W'(1);
    else if (cnt_q != '0) cnt_d = cnt_q - PHASE_W'(1);
    last = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2c_cond_seq_engine.sv
module i2c_cond_seq_engine
  import i2c_cond_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic       cmd_stop,
  input  logic       cmd_rs,
  input  logic       byte_go,
  input  logic [7:0] byte_val,
  input  logic       phase_last,
  input  logic       sda_in,
  output logic       tmr_load,
  output logic       tmr_high,
  output logic       busy,
  output logic       done_pulse,
  output logic       nak,
  output logic       scl_drv,
  output logic       sda_drv,
  output logic       in_byte
);

  seq_state_e state_q, state_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       hold_scl_q, hold_scl_d;
  logic       hold_sda_q, hold_sda_d;
  logic       nak_q, nak_d;

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    hold_scl_d = hold_scl_q;
    hold_sda_d = hold_sda_q;
    nak_d      = nak_q;
    tmr_load   = 1'b0;
    tmr_high   = 1'b0;
    done_pulse = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (cmd_go) begin
          tmr_load = 1'b1;
          if (cmd_stop) begin
            state_d = SQ_SP_LOW;
          end else if (cmd_rs) begin
            state_d = SQ_RS_LOW;
          end else begin
            state_d  = SQ_ST_SETUP;
            tmr_high = 1'b1;
          end
        end else if (byte_go) begin
          tmr_load = 1'b1;
          sh_d     = byte_val;
          bit_d    = 3'd7;
          state_d  = SQ_BIT_LOW;
        end
      end
      SQ_RS_LOW: if (phase_last) begin
        state_d = SQ_ST_SETUP; tmr_load = 1'b1; tmr_high = 1'b1;
      end
      SQ_ST_SETUP: if (phase_last) begin
        state_d = SQ_ST_HOLD; tmr_load = 1'b1; tmr_high = 1'b1;
      end
      SQ_ST_HOLD: if (phase_last) begin
        state_d = SQ_IDLE; hold_scl_d = 1'b1; hold_sda_d = 1'b1; done_pulse = 1'b1;
      end
      SQ_SP_LOW: if (phase_last) begin
        state_d = SQ_SP_HIGH; tmr_load = 1'b1; tmr_high = 1'b1;
      end
      SQ_SP_HIGH: if (phase_last) begin
        state_d = SQ_SP_REL; tmr_load = 1'b1; tmr_high = 1'b1;
      end
      SQ_SP_REL: if (phase_last) begin
        state_d = SQ_IDLE; hold_scl_d = 1'b0; hold_sda_d = 1'b0; done_pulse = 1'b1;
      end
      SQ_BIT_LOW: if (phase_last) begin
        state_d = SQ_BIT_HIGH; tmr_load = 1'b1; tmr_high = 1'b1;
      end
      SQ_BIT_HIGH: if (phase_last) begin
        tmr_load = 1'b1;
        if (bit_q == 3'd0) begin
          state_d = SQ_ACK_LOW;
        end else begin
          bit_d   = bit_q - 3'd1;
          sh_d    = {sh_q[6:0], 1'b0};
          state_d = SQ_BIT_LOW;
        end
      end
      SQ_ACK_LOW: if (phase_last) begin
        state_d = SQ_ACK_HIGH; tmr_load = 1'b1; tmr_high = 1'b1;
      end
      SQ_ACK_HIGH: if (phase_last) begin
        nak_d      = sda_in;
        state_d    = SQ_IDLE;
        hold_scl_d = 1'b1;
        hold_sda_d = 1'b0;
        done_pulse = 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    case (state_q)
      SQ_IDLE:     begin scl_drv = hold_scl_q; sda_drv = hold_sda_q; end
      SQ_RS_LOW:   begin scl_drv = 1'b1; sda_drv = 1'b0; end
      SQ_ST_SETUP: begin scl_drv = 1'b0; sda_drv = 1'b0; end
      SQ_ST_HOLD:  begin scl_drv = 1'b0; sda_drv = 1'b1; end
      SQ_SP_LOW:   begin scl_drv = 1'b1; sda_drv = 1'b1; end
      SQ_SP_HIGH:  begin scl_drv = 1'b0; sda_drv = 1'b1; end
      SQ_SP_REL:   begin scl_drv = 1'b0; sda_drv = 1'b0; end
      SQ_BIT_LOW:  begin scl_drv = 1'b1; sda_drv = !sh_q[7]; end
      SQ_BIT_HIGH: begin scl_drv = 1'b0; sda_drv = !sh_q[7]; end
      SQ_ACK_LOW:  begin scl_drv = 1'b1; sda_drv = 1'b0; end
      SQ_ACK_HIGH: begin scl_drv = 1'b0; sda_drv = 1'b0; end
      default:     begin scl_drv = 1'b0; sda_drv = 1'b0; end
    endcase
    busy    = (state_q != SQ_IDLE);
    in_byte = (state_q == SQ_BIT_LOW) || (state_q == SQ_BIT_HIGH) ||
              (state_q == SQ_ACK_LOW) || (state_q == SQ_ACK_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      bit_q      <= 3'd0;
      sh_q       <= 8'h00;
      hold_scl_q <= 1'b0;
      hold_sda_q <= 1'b0;
      nak_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_q      <= bit_d;
      sh_q       <= sh_d;
      hold_scl_q <= hold_scl_d;
      hold_sda_q <= hold_sda_d;
      nak_q      <= nak_d;
    end
  end

  assign nak = nak_q;

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_seq_pkg::*;
#(
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned DEF_TLOW  = 5,
  parameter int unsigned DEF_THIGH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);

  logic               cmd_go, cmd_stop, cmd_rs, byte_go;
  logic [7:0]         byte_val;
  logic               ien, done, busy, done_pulse, nak;
  logic [PHASE_W-1:0] tlow, thigh;
  logic               tmr_load, tmr_high, phase_last;
  logic               scl_drv, sda_drv, in_byte;
  logic               scl_oe_q, sda_oe_q, byte_drv_q, irq_q;

  i2c_cond_seq_regs #(
    .PHASE_W(PHASE_W), .DEF_TLOW(DEF_TLOW), .DEF_THIGH(DEF_THIGH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_pulse(done_pulse), .nak(nak), .cmd_go(cmd_go),
    .cmd_stop(cmd_stop), .cmd_rs(cmd_rs), .byte_go(byte_go),
    .byte_val(byte_val), .ien(ien), .done(done), .tlow(tlow), .thigh(thigh)
  );

  i2c_cond_seq_timer #(.PHASE_W(PHASE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .use_high(tmr_high),
    .tlow(tlow), .thigh(thigh), .last(phase_last)
  );

  i2c_cond_seq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_stop(cmd_stop),
    .cmd_rs(cmd_rs), .byte_go(byte_go), .byte_val(byte_val),
    .phase_last(phase_last), .sda_in(sda_i), .tmr_load(tmr_load),
    .tmr_high(tmr_high), .busy(busy), .done_pulse(done_pulse), .nak(nak),
    .scl_drv(scl_drv), .sda_drv(sda_drv), .in_byte(in_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe_q   <= 1'b0;
      sda_oe_q   <= 1'b0;
      byte_drv_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      scl_oe_q   <= scl_drv;
      sda_oe_q   <= sda_drv;
      byte_drv_q <= in_byte;
      irq_q      <= done && ien;
    end
  end

  assign scl_oe = scl_oe_q;
  assign sda_oe = sda_oe_q;
  assign irq    = irq_q;

endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_go,
  input logic byte_go,
  input logic busy,
  input logic done,
  input logic ien,
  input logic irq,
  input logic nak,
  input logic scl_oe,
  input logic sda_oe,
  input logic byte_drv_q
);

  // R7
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go || byte_go) |-> !busy);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ien));

  // R6
  nak_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nak) |-> $past(busy));

  // R12
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_drv_q && $past(byte_drv_q) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

endmodule

bind i2c_cond_seq i2c_cond_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .byte_go(byte_go),
  .busy(busy), .done(done), .ien(ien), .irq(irq), .nak(nak),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .byte_drv_q(byte_drv_q)
);

// File: tb/sim_i2c_cond_seq.sv
`timescale 1ns/1ps
module sim_i2c_cond_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       slave_drv = 1'b0;
  logic       slave_ack = 1'b1;
  logic       scl_ln, sda_ln;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign scl_ln = !scl_oe;
  assign sda_ln = !(sda_oe || slave_drv);

  i2c_cond_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  // bus monitor and acknowledging slave
  logic p_scl = 1'b1, p_sda = 1'b1;
  int   bitcnt = 0, starts = 0, stops = 0, bytes = 0, edges = 0;
  int   hi_run = 0, lo_run = 0;
  int   hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;
  logic [7:0] rx_sh = 8'h00, rx_last = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_ln != p_scl) edges <= edges + 1;
      if (scl_ln && p_scl && p_sda && !sda_ln) begin
        starts <= starts + 1; bitcnt <= 0;
      end else if (scl_ln && p_scl && !p_sda && sda_ln) begin
        stops <= stops + 1; bitcnt <= 0;
      end else if (scl_ln && !p_scl) begin
        if (bitcnt >= 1 && bitcnt <= 8) begin
          if (lo_run < lo_min) lo_min <= lo_run;
          if (lo_run > lo_max) lo_max <= lo_run;
        end
        if (bitcnt < 8) rx_sh <= {rx_sh[6:0], sda_ln};
        bitcnt <= bitcnt + 1;
        hi_run <= 1;
      end else if (!scl_ln && p_scl) begin
        if (bitcnt >= 1 && bitcnt <= 9) begin
          if (hi_run < hi_min) hi_min <= hi_run;
          if (hi_run > hi_max) hi_max <= hi_run;
        end
        if (bitcnt == 8) slave_drv <= slave_ack;
        if (bitcnt == 9) begin
          slave_drv <= 1'b0; bitcnt <= 0; bytes <= bytes + 1; rx_last <= rx_sh;
        end
        lo_run <= 1;
      end else if (scl_ln) hi_run <= hi_run + 1;
      else lo_run <= lo_run + 1;
      p_scl <= scl_ln;
      p_sda <= sda_ln;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd2, s);
      if (!s[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_win();
    hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int s0, b0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check(r == 8'h00, "R1 ctrl", r, 0);
    rd(3'd2, r); check(r == 8'h00, "R1 status", r, 0);
    rd(3'd4, r); check(r == 8'd5, "R1 tlow", r, 5);
    rd(3'd5, r); check(r == 8'd4, "R1 thigh", r, 4);
    check(scl_ln && sda_ln && !irq, "R1 lines", {scl_ln, sda_ln, irq}, 6);

    wr(3'd4, 8'd3); wr(3'd5, 8'd2); wr(3'd3, 8'd1);

    // R11 disabled byte write and no-action commands
    e0 = edges;
    wr(3'd1, 8'h55); repeat (60) @(negedge clk);
    rd(3'd2, r); check(r[0] == 1'b0, "R11 busy disabled", r, 0);
    wr(3'd0, 8'h01); wr(3'd0, 8'h07); repeat (60) @(negedge clk);
    rd(3'd2, r); check(r == 8'h00, "R11 no-action status", r, 0);
    check(edges == e0, "R11 no bus movement", edges - e0, 0);

    // R2 START, R7 busy and interlock
    s0 = starts;
    wr(3'd0, 8'h03);
    rd(3'd2, r); check(r[0] == 1'b1, "R7 busy after launch", r[0], 1);
    wr(3'd0, 8'h05);
    wait_idle();
    check(starts == s0 + 1, "R2 start seen", starts - s0, 1);
    check(!scl_ln && !sda_ln, "R2 lines held low", {scl_ln, sda_ln}, 0);
    rd(3'd0, r); check(r[2:1] == 2'd1, "R7 ctrl write while busy ignored", r[2:1], 1);
    check(stops == 0, "R7 no stop from ignored write", stops, 0);
    rd(3'd2, r); check(r[1] == 1'b1, "R8 done set", r[1], 1);
    check(irq == 1'b1, "R9 irq with enable", irq, 1);
    wr(3'd2, 8'h00); rd(3'd2, r); check(r[1] == 1'b1, "R8 write 0 keeps done", r[1], 1);
    wr(3'd2, 8'h02); repeat (2) @(negedge clk);
    rd(3'd2, r); check(r[1] == 1'b0, "R8 w1c clears", r[1], 0);
    check(irq == 1'b0, "R9 irq drops", irq, 0);
    wr(3'd0, 8'h01);

    // R5 R6 R10 R12 byte sweep over phase settings
    for (int c = 0; c < 3; c++) begin
      int tl, th;
      tl = (c == 0) ? 1 : (c == 1) ? 3 : 0;
      th = (c == 0) ? 1 : (c == 1) ? 2 : 4;
      wr(3'd4, 8'(tl)); wr(3'd5, 8'(th));
      for (int v = 0; v < 10; v++) begin
        logic [7:0] d;
        d = (v == 8) ? 8'h00 : (v == 9) ? 8'hFF : 8'(v * 37 + 5);
        slave_ack = (v % 2 == 0);
        clear_win();
        b0 = bytes; s0 = starts + stops;
        wr(3'd1, d);
        wr(3'd1, ~d);
        wait_idle();
        check(bytes == b0 + 1, "R7 one byte per launch", bytes - b0, 1);
        check(rx_last == d, "R5 byte MSB first", rx_last, d);
        rd(3'd1, r); check(r == d, "R7 data write while busy ignored", r, d);
        rd(3'd0, r); check(r[3] == !slave_ack, "R6 ack readback", r[3], !slave_ack);
        check(hi_min == ((th == 0) ? 1 : th) && hi_max == hi_min, "R10 high phase", hi_max, th);
        check(lo_min == ((tl == 0) ? 1 : tl) && lo_max == lo_min, "R10 low phase", lo_max, tl);
        check(starts + stops == s0, "R12 no condition inside byte", starts + stops - s0, 0);
        wr(3'd2, 8'h02);
      end
    end

    // R3 repeated START
    s0 = starts;
    wr(3'd4, 8'd2); wr(3'd5, 8'd2);
    wr(3'd0, 8'h0B); wait_idle();
    check(starts == s0 + 1, "R3 repeated start", starts - s0, 1);
    check(stops == 0, "R3 no stop", stops, 0);
    wr(3'd0, 8'h01);

    // R4 STOP
    wr(3'd0, 8'h05); wait_idle();
    check(stops == 1, "R4 stop seen", stops, 1);
    check(scl_ln && sda_ln, "R4 released", {scl_ln, sda_ln}, 3);
    wr(3'd0, 8'h01); wr(3'd2, 8'h02);

    // R9 interrupt disabled
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h03); wait_idle();
    rd(3'd2, r); check(r[1] == 1'b1, "R9 done without enable", r[1], 1);
    check(irq == 1'b0, "R9 irq masked", irq, 0);
    wr(3'd0, 8'h01); wr(3'd0, 8'h05); wait_idle();
    check(stops == 2, "R4 second stop", stops, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule